// File: doc/BRIEF.md
# Character LCD Host Serial Port

This block is the host-facing serial front end of a character LCD controller. A host drives a chip select, a shift clock, a serial data line and a command/data select line. The port collects eight serial bits into one word, tags the word as a command or as display data, and hands it to the controller core as a one-cycle strobe. The core then needs some time to process the word. For that time the port holds a busy window whose length depends on the panel duty mode.

There is one serial output pin. It is modelled as a data value plus a drive enable, and it carries two kinds of information. While the busy window is open it reports busy. Outside that window it shifts out, least significant bit first, a read byte that the core supplies from its address pointer. The host can leave the pin undriven: a drive-enable flag, written by the core when it decodes the matching command, decides whether the pin drives at all.

All host inputs come from another clock domain. They are resynchronised into the master clock domain, and shift-clock edges are detected there.

Top module: `lcdc_host_serial`

## Requirements
- R1: After reset, with chip select high and the drive flag set, `word_vld_o` is low and `sdo_o` is high.
- R2: Eight shift-clock rising edges taken while chip select is high form one word. The first bit goes to bit 0, and the eighth bit goes to bit 7. `word_vld_o` is high for exactly one master clock per word.
- R3: `word_cmd_o` takes the level of `cd_i` at the eighth rising edge: 1 means command, 0 means display data. The level of `cd_i` at the first seven edges has no effect.
- R4: While chip select is low, shift-clock edges are not counted and the bit count returns to zero. A partial word is dropped, and the next word is built from eight new edges.
- R5: `sdo_en_o` is high only while chip select is high and the drive flag is 1. The flag is written from `oe_val_i` when `oe_wr_i` is high. Reset leaves the flag unchanged.
- R6: When a word completes, `sdo_o` goes low. It starts in the same master clock as `word_vld_o` and stays low for exactly 10 master clocks when `duty9_i`=0, or 20 when `duty9_i`=1. It then returns high.
- R7: Shift-clock rising edges that arrive during the busy window are ignored.
- R8: At the first edge of a word the port captures `rd_byte_i`. After edge k, for k from 1 to 7, `sdo_o` shows bit k-1 of the captured byte.
- R9: If chip select drops after k edges (k from 1 to 7) and is raised again, no new byte is captured. The first edge after the re-raise shows bit k. Bit positions past bit 7 read as 0.
- R10: When no bit of a word has been counted, no read is pending and the port is not busy, `sdo_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sck_i | input | 1 | Shift clock, rising edge active, asynchronous |
| sdi_i | input | 1 | Serial data in |
| cd_i | input | 1 | Command (1) / display data (0) select |
| duty9_i | input | 1 | 1: 9-row duty (long busy), 0: 17-row duty (short busy) |
| rd_byte_i | input | 8 | Byte at the current address pointer, from the core |
| oe_wr_i | input | 1 | Write strobe for the drive-enable flag |
| oe_val_i | input | 1 | Value written to the drive-enable flag |
| word_vld_o | output | 1 | One-cycle strobe for a completed word |
| word_byte_o | output | 8 | Completed word |
| word_cmd_o | output | 1 | Completed word is a command |
| sdo_o | output | 1 | Serial output value |
| sdo_en_o | output | 1 | Serial output drive enable (low means high impedance) |

## Verification
The bench measures the busy window in master clocks for both duty settings. A timer that is off by one, or that uses the wrong duty value, shows up as a wrong low-run length on the output.

It also drives a shift edge into the busy window and then sends a whole word. If that edge were counted, every later word would be shifted by one bit.

Chip select is dropped partway through a word and partway through a read. The following word must come out aligned, and the read must resume at the right bit rather than restart from a newly captured byte, which would show up as the wrong bit values.

The command flag is driven to the opposite level before the last edge, so a design that sampled it early reports the wrong word type.

// File: rtl/lcdsp_pkg.sv
// Shared types for the host serial port.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lcdsp_pkg;

    // Which source drives the serial output value.
    typedef enum logic [1:0] {
        SDO_READY = 2'd0,
        SDO_BUSY  = 2'd1,
        SDO_DATA  = 2'd2
    } sdo_src_e;

    // Pick the output source from the port state; busy has priority.
    function automatic sdo_src_e pick_src(input logic busy, input logic reading);
        if (busy)         return SDO_BUSY;
        else if (reading) return SDO_DATA;
        else              return SDO_READY;
    endfunction

endpackage

// File: rtl/lcdsp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous host lines.
// Assumes: each bit is an independent level; STAGES >= 2. All lines get
// the same latency, so data sampled with a clock edge stays aligned.
module lcdsp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lcdsp_rx.sv
// Serial word assembler. Detects rising shift edges in the master clock
// domain and collects bits first-to-bit-0. When a word completes it
// registers the word with its command flag.
// Assumes: inputs are already synchronised. The shift clock is treated
// as high while chip select is low. Edges are dropped while busy.
module lcdsp_rx #(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          cd_s,
    input  logic          busy,
    output logic          edge_ok,
    output logic [CW-1:0] cnt_o,
    output logic          cs_fall,
    output logic          done,
    output logic          word_vld,
    output logic [W-1:0]  word_byte,
    output logic          word_cmd
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sck_q, cs_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sh_q;
    logic          sck_int;

    assign sck_int = sck_s | ~cs_s;
    assign edge_ok = cs_s & sck_s & ~sck_q & ~busy;
    assign cs_fall = cs_q & ~cs_s;
    assign done    = edge_ok && (cnt_q == LAST);
    assign cnt_o   = cnt_q;

    // Remember the previous gated shift clock and chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            cs_q  <= 1'b0;
        end else begin
            sck_q <= sck_int;
            cs_q  <= cs_s;
        end
    end

    // Count bits and collect them; clear the count when chip select drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (edge_ok) begin
            sh_q[cnt_q] <= sdi_s;
            cnt_q       <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Register the finished word and raise the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld  <= 1'b0;
            word_byte <= '0;
            word_cmd  <= 1'b0;
        end else begin
            word_vld <= done;
            if (done) begin
                word_byte <= {sdi_s, sh_q[W-2:0]};
                word_cmd  <= cd_s;
            end
        end
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R2
    AST_CMD_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (word_cmd == $past(cd_s))); // R3
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_s) |=> $stable(cnt_q)); // R7
    AST_CLEAR_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/lcdsp_busy.sv
// Busy window timer. Loads a duty-dependent length when a word completes
// and counts down to zero; busy is high while the count is non-zero.
// Assumes: load is a single-cycle pulse; BUSY_LONG >= BUSY_SHORT >= 1.
module lcdsp_busy #(
    parameter int BUSY_SHORT = 10,
    parameter int BUSY_LONG  = 20,
    localparam int BW = $clog2(BUSY_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic duty9,
    output logic busy
);
    logic [BW-1:0] cnt_q;

    // Load the window length on completion, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= duty9 ? BW'(BUSY_LONG) : BW'(BUSY_SHORT);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy); // R6
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BW'(BUSY_LONG)); // R6
endmodule

// File: rtl/lcdsp_tx.sv
// Serial output stage. Holds the read shifter, the pending-read flag and
// the drive-enable flag, and selects ready, busy or read data.
// Assumes: edge_ok, cnt and cs_fall come from the assembler; cnt is the
// count before the current edge. The enable flag has no reset.
module lcdsp_tx #(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          edge_ok,
    input  logic [CW-1:0] cnt,
    input  logic          cs_fall,
    input  logic          busy,
    input  logic [W-1:0]  rd_byte,
    input  logic          oe_wr,
    input  logic          oe_val,
    output logic          sdo,
    output logic          sdo_en
);
    import lcdsp_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0] rd_sh;
    logic         rd_part;
    logic         oe_q;
    sdo_src_e     src;

    // Drive-enable flag: written only by the core's strobe, unaffected by reset.
    always_ff @(posedge clk) begin
        if (oe_wr) oe_q <= oe_val;
    end

    // Capture the read byte at the first edge; otherwise shift in zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else if (edge_ok) begin
            if (cnt == '0 && !rd_part) rd_sh <= rd_byte;
            else                       rd_sh <= {1'b0, rd_sh[W-1:1]};
        end
    end

    // Mark a read cut short by deselect; clear it when a word completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_part <= 1'b0;
        else if (cs_fall && cnt != '0)       rd_part <= 1'b1;
        else if (edge_ok && cnt == LAST)     rd_part <= 1'b0;
    end

    // Select the output source and gate the driver.
    always_comb begin
        src    = pick_src(busy, (cnt != '0) || rd_part);
        sdo_en = cs_s & oe_q;
        unique case (src)
            SDO_BUSY: sdo = 1'b0;
            SDO_DATA: sdo = rd_sh[0];
            default:  sdo = 1'b1;
        endcase
    end

    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && busy) |-> !sdo); // R6
    AST_PART_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ok && cnt == LAST) |=> !rd_part); // R9
    AST_FLAG_HELD: assert property (@(posedge clk)
        !oe_wr |=> $stable(oe_q)); // R5
endmodule

// File: rtl/lcdc_host_serial.sv
// Top of the host serial port: synchronisers, word assembler, busy
// timer and serial output stage.
// Assumes: the host meets the slow shift-clock timing of the master clock
// domain (each shift-clock level lasts several master clocks).
module lcdc_host_serial #(
    parameter int W          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_SHORT = 10,
    parameter int BUSY_LONG  = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_i,
    input  logic         sck_i,
    input  logic         sdi_i,
    input  logic         cd_i,
    input  logic         duty9_i,
    input  logic [W-1:0] rd_byte_i,
    input  logic         oe_wr_i,
    input  logic         oe_val_i,
    output logic         word_vld_o,
    output logic [W-1:0] word_byte_o,
    output logic         word_cmd_o,
    output logic         sdo_o,
    output logic         sdo_en_o
);
    localparam int CW = $clog2(W);

    logic [3:0]    raw, syn;
    logic          cs_s, sck_s, sdi_s, cd_s;
    logic          edge_ok, cs_fall, done, busy;
    logic [CW-1:0] cnt;

    assign raw = {cd_i, sdi_i, sck_i, cs_i};
    assign {cd_s, sdi_s, sck_s, cs_s} = syn;

    lcdsp_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .rst_val(4'b0010), .q(syn)
    );

    lcdsp_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
        .cd_s(cd_s), .busy(busy), .edge_ok(edge_ok), .cnt_o(cnt),
        .cs_fall(cs_fall), .done(done), .word_vld(word_vld_o),
        .word_byte(word_byte_o), .word_cmd(word_cmd_o)
    );

    lcdsp_busy #(.BUSY_SHORT(BUSY_SHORT), .BUSY_LONG(BUSY_LONG)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(done), .duty9(duty9_i), .busy(busy)
    );

    lcdsp_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .edge_ok(edge_ok), .cnt(cnt),
        .cs_fall(cs_fall), .busy(busy), .rd_byte(rd_byte_i), .oe_wr(oe_wr_i),
        .oe_val(oe_val_i), .sdo(sdo_o), .sdo_en(sdo_en_o)
    );

    AST_STROBE_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> busy); // R6
endmodule

// File: tb/test_lcdc_host_serial.sv
module test_lcdc_host_serial;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, sck = 1'b1, sdi = 1'b0, cd = 1'b0, duty9 = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       oe_wr = 1'b0, oe_val = 1'b0;
    logic       word_vld, word_cmd, sdo, sdo_en;
    logic [7:0] word_byte;

    int n_run = 0, n_fail = 0;
    int vld_seen = 0, run = 0, last_run = 0;
    logic [7:0] got_byte = 8'h00;
    logic       got_cmd = 1'b0;

    always #2 clk = ~clk;

    lcdc_host_serial i_lcdc_host_serial (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi), .cd_i(cd),
        .duty9_i(duty9), .rd_byte_i(rd_byte), .oe_wr_i(oe_wr), .oe_val_i(oe_val),
        .word_vld_o(word_vld), .word_byte_o(word_byte), .word_cmd_o(word_cmd),
        .sdo_o(sdo), .sdo_en_o(sdo_en)
    );

    // Watch strobes and the length of each low run on the driven output.
    always @(negedge clk) begin
        if (word_vld) begin
            vld_seen++;
            got_byte = word_byte;
            got_cmd  = word_cmd;
        end
        if (sdo_en && !sdo) run++;
        else begin
            if (run != 0) last_run = run;
            run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b, input logic c);
        @(negedge clk);
        sdi = b; cd = c; sck = 1'b0;
        wait_clk(6);
        sck = 1'b1;
        wait_clk(6);
    endtask

    task automatic send_word(input logic [7:0] b, input logic c);
        for (int i = 0; i < 8; i++) shift_bit(b[i], c);
    endtask

    task automatic t_reset;
        @(negedge clk); oe_wr = 1'b1; oe_val = 1'b1;
        @(negedge clk); oe_wr = 1'b0;
        wait_clk(3); rst_n = 1'b1; cs = 1'b1;
        wait_clk(6);
        check(word_vld == 1'b0, "R1 strobe idle", word_vld, 0);
        check(sdo_en && sdo, "R1 ready level", sdo, 1);
        check(sdo, "R10 idle high", sdo, 1);
    endtask

    task automatic t_data_word;
        int v0;
        v0 = vld_seen; last_run = 0; duty9 = 1'b0; rd_byte = 8'hFF;
        send_word(8'hA5, 1'b0);
        wait_clk(25);
        check(got_byte == 8'hA5, "R2 byte", got_byte, 8'hA5);
        check(vld_seen == v0 + 1, "R2 one strobe", vld_seen - v0, 1);
        check(got_cmd == 1'b0, "R3 data flag", got_cmd, 0);
        check(last_run == 10, "R6 short busy", last_run, 10);
        check(sdo, "R6 back high", sdo, 1);
    endtask

    task automatic t_cmd_flag;
        for (int i = 0; i < 7; i++) shift_bit(1'b0, 1'b0);
        shift_bit(1'b1, 1'b1);
        wait_clk(25);
        check(got_cmd == 1'b1, "R3 cmd at last edge", got_cmd, 1);
        check(got_byte == 8'h80, "R2 bit order", got_byte, 8'h80);
        for (int i = 0; i < 7; i++) shift_bit(1'b1, 1'b1);
        shift_bit(1'b0, 1'b0);
        wait_clk(25);
        check(got_cmd == 1'b0, "R3 early cd ignored", got_cmd, 0);
        check(got_byte == 8'h7F, "R2 byte", got_byte, 8'h7F);
    endtask

    task automatic t_long_busy_and_ignore;
        int v0;
        duty9 = 1'b1; last_run = 0; rd_byte = 8'hFF;
        send_word(8'h11, 1'b0);
        sck = 1'b0; wait_clk(2); sck = 1'b1; wait_clk(2);
        wait_clk(40);
        check(last_run == 20, "R6 long busy", last_run, 20);
        v0 = vld_seen;
        send_word(8'h5A, 1'b0);
        wait_clk(40);
        check(got_byte == 8'h5A, "R7 edge in busy ignored", got_byte, 8'h5A);
        check(vld_seen == v0 + 1, "R7 strobe count", vld_seen - v0, 1);
        duty9 = 1'b0;
    endtask

    task automatic t_deselect_drop;
        int v0;
        v0 = vld_seen;
        shift_bit(1'b1, 1'b0); shift_bit(1'b1, 1'b0); shift_bit(1'b1, 1'b0);
        cs = 1'b0; wait_clk(6);
        check(sdo_en == 1'b0, "R5 released when deselected", sdo_en, 0);
        cs = 1'b1; wait_clk(6);
        send_word(8'h96, 1'b0);
        wait_clk(25);
        check(got_byte == 8'h96, "R4 partial dropped", got_byte, 8'h96);
        check(vld_seen == v0 + 1, "R4 strobe count", vld_seen - v0, 1);
    endtask

    task automatic t_enable_flag;
        rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(6);
        check(sdo_en == 1'b1, "R5 flag kept by reset", sdo_en, 1);
        @(negedge clk); oe_wr = 1'b1; oe_val = 1'b0;
        @(negedge clk); oe_wr = 1'b0;
        wait_clk(2);
        check(sdo_en == 1'b0, "R5 flag cleared", sdo_en, 0);
        @(negedge clk); oe_wr = 1'b1; oe_val = 1'b1;
        @(negedge clk); oe_wr = 1'b0;
        wait_clk(2);
        check(sdo_en == 1'b1, "R5 flag set", sdo_en, 1);
    endtask

    task automatic t_read;
        rd_byte = 8'hB5;
        for (int k = 1; k <= 7; k++) begin
            shift_bit(1'b0, 1'b0);
            check(sdo == rd_byte[k-1], "R8 read bit", sdo, rd_byte[k-1]);
        end
        shift_bit(1'b0, 1'b0);
        wait_clk(25);
        check(sdo == 1'b1, "R10 ready after read", sdo, 1);
    endtask

    task automatic t_partial_read;
        logic [7:0] ref_b;
        ref_b = 8'hC6; rd_byte = ref_b;
        for (int k = 1; k <= 3; k++) begin
            shift_bit(1'b0, 1'b0);
            check(sdo == ref_b[k-1], "R8 read bit", sdo, ref_b[k-1]);
        end
        cs = 1'b0; wait_clk(6);
        rd_byte = 8'hFF;
        cs = 1'b1; wait_clk(6);
        for (int k = 1; k <= 7; k++) begin
            shift_bit(1'b0, 1'b0);
            if (k + 2 <= 7)
                check(sdo == ref_b[k+2], "R9 resumed bit", sdo, ref_b[k+2]);
            else
                check(sdo == 1'b0, "R9 zero fill", sdo, 0);
        end
        shift_bit(1'b0, 1'b0);
        wait_clk(25);
    endtask

    initial begin : watchdog
        wait_clk(150000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_data_word();
        t_cmd_flag();
        t_long_busy_and_ignore();
        t_deselect_drop();
        t_enable_flag();
        t_read();
        t_partial_read();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule